// File: doc/BRIEF.md
# Multi-Bank Level Interrupt Aggregator

This block gathers level-sensitive interrupt lines arranged in banks of 32 and turns them into three request outputs: a normal request, a fast request and an endpoint request. Every bank has its own enable mask for each of the three outputs. An output is high while any bank holds a source that is both asserted and enabled in that output's mask. The live input levels are visible as a cause word. Nothing is latched, so nothing needs to be acknowledged: a cause bit drops when its line drops.

Software reaches the block through a simple single-cycle bus. A bank select and a byte offset pick one 32-bit word. Writes take effect at the next clock edge, and read data is a combinational function of the current select, offset and state. Each bank also has a status word that names the highest-numbered source that is pending and enabled in the normal mask, so that a handler can service sources from the top bit downward. Every input passes through a synchronizer before it reaches the cause word.

Top module: `intr_gather`

## Requirements
- R1: Reading word offset 0x00 of a bank returns that bank's 32 input lines as they were two clock edges earlier (two-flop synchronizer). A cause bit stays set exactly as long as its line stays high, and needs no write to clear it.
- R2: The normal mask sits at offset 0x04, the fast mask at 0x08 and the endpoint mask at 0x0C. Each reads back the last value written to it, and all masks are zero after reset. A mask bit of 1 enables the source with the same bit number.
- R3: A write to offset 0x00 or to offset 0x10 changes no state: the cause word and every mask read back the same values as without the write.
- R4: `irq_norm` is the OR over all banks and all bits of cause AND normal mask.
- R5: `irq_fast` and `irq_endp` are formed the same way, each from its own mask (fast, endpoint) and independent of the other masks.
- R6: Offset 0x10 returns a status word. Bit 8 is a valid flag and bits 4:0 hold the highest bit number set in cause AND normal mask. The word is all zero when no such bit is set, and all other bits always read 0.
- R7: Writing zero to a bank's normal mask stops every source of that bank from driving `irq_norm`, whatever its input levels.
- R8: Reads return 0 when the bank select is at or above NUM_BANKS, when the offset is not word aligned (bits 1:0 not 00), or when the offset is above 0x10. Writes to any such address change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NUM_BANKS*32 | Level interrupt lines; bank b occupies bits b*32+31 down to b*32 |
| bus_wr | input | 1 | Write strobe, takes effect at the next rising edge |
| bus_sel | input | SEL_W | Bank select |
| bus_off | input | 5 | Byte offset within the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current select and offset |
| irq_norm | output | 1 | Normal interrupt request |
| irq_fast | output | 1 | Fast interrupt request |
| irq_endp | output | 1 | Endpoint interrupt request |

## Verification
The input lines are driven first with a single set bit walked across every bank. This separates the bank and bit mapping of the cause word and of the status index. Random multi-bit patterns with bursts of random mask writes come next. They show whether the three outputs really use separate masks and whether the status word picks the highest pending bit rather than the lowest. Interleaved writes to the cause and status offsets, to misaligned offsets and to a bank select past the last bank tell address decoding apart from mask storage. A final phase holds every line high with all normal masks cleared, which shows that clearing a mask silences a bank while the fast and endpoint paths stay live.

// File: rtl/intr_gather_pkg.sv
package intr_gather_pkg;
   localparam int SRC_PER_BANK = 32;
   localparam int NUM_MASKS    = 3;
   localparam int IDX_W        = $clog2(SRC_PER_BANK);
   localparam int OFF_W        = 5;
   localparam int STAT_VLD_BIT = 8;

   // word index = byte offset / 4
   typedef enum logic [2:0] {
      WRD_CAUSE = 3'd0,
      WRD_NORM  = 3'd1,
      WRD_FAST  = 3'd2,
      WRD_ENDP  = 3'd3,
      WRD_STAT  = 3'd4
   } word_e;

   // mask slot numbering inside a bank
   localparam int MSK_NORM = 0;
   localparam int MSK_FAST = 1;
   localparam int MSK_ENDP = 2;
endpackage

// File: rtl/intr_gather_sync.sv
module intr_gather_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("intr_gather_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("intr_gather_sync: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[0] <= '0;
      else        stg_q[0] <= d;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= '0;
            else        stg_q[s] <= stg_q[s-1];
         end
      end
   endgenerate

   assign q = stg_q[STAGES-1];
endmodule

// File: rtl/intr_gather_bank.sv
module intr_gather_bank
   import intr_gather_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic [SRC_PER_BANK-1:0]                src,
   input  logic                                   wr_en,
   input  logic [1:0]                             wr_slot,
   input  logic [31:0]                            wdata,
   output logic [SRC_PER_BANK-1:0]                cause,
   output logic [NUM_MASKS-1:0][SRC_PER_BANK-1:0] mask_q,
   output logic [NUM_MASKS-1:0]                   req,
   output logic                                   top_vld,
   output logic [IDX_W-1:0]                       top_idx
);
   intr_gather_sync #(
      .WIDTH  (SRC_PER_BANK),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (src),
      .q     (cause)
   );

   generate
      for (genvar m = 0; m < NUM_MASKS; m++) begin : g_mask
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mask_q[m] <= '0;
            else if (wr_en && (wr_slot == 2'(m)))
               mask_q[m] <= wdata;
         end
         assign req[m] = |(cause & mask_q[m]);
      end
   endgenerate

   // ascending scan: the last hit is the highest bit number
   logic [SRC_PER_BANK-1:0] pend;
   assign pend = cause & mask_q[MSK_NORM];

   always_comb begin
      top_vld = 1'b0;
      top_idx = '0;
      for (int i = 0; i < SRC_PER_BANK; i++) begin
         if (pend[i]) begin
            top_vld = 1'b1;
            top_idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/intr_gather.sv
module intr_gather
   import intr_gather_pkg::*;
#(
   parameter int NUM_BANKS   = 3,
   parameter int SYNC_STAGES = 2,
   parameter int SEL_W       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_BANKS*SRC_PER_BANK-1:0] irq_src,
   input  logic                              bus_wr,
   input  logic [SEL_W-1:0]                  bus_sel,
   input  logic [OFF_W-1:0]                  bus_off,
   input  logic [31:0]                       bus_wdata,
   output logic [31:0]                       bus_rdata,
   output logic                              irq_norm,
   output logic                              irq_fast,
   output logic                              irq_endp
);
   generate
      if (NUM_BANKS < 1) begin : g_bad_banks
         $error("intr_gather: NUM_BANKS must be at least 1");
      end
      if ((2 ** SEL_W) < NUM_BANKS) begin : g_bad_sel
         $error("intr_gather: SEL_W too narrow for NUM_BANKS");
      end
   endgenerate

   logic       aligned;
   word_e      word;
   logic       is_mask_word;
   logic [1:0] wr_slot;

   assign aligned      = (bus_off[1:0] == 2'b00);
   assign word         = word_e'(bus_off[4:2]);
   assign is_mask_word = aligned && (word == WRD_NORM || word == WRD_FAST || word == WRD_ENDP);
   assign wr_slot      = bus_off[3:2] - 2'd1;

   logic [SRC_PER_BANK-1:0]                cause_a [NUM_BANKS];
   logic [NUM_MASKS-1:0][SRC_PER_BANK-1:0] mask_a  [NUM_BANKS];
   logic [NUM_MASKS-1:0]                   req_a   [NUM_BANKS];
   logic                                   vld_a   [NUM_BANKS];
   logic [IDX_W-1:0]                       idx_a   [NUM_BANKS];

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         logic wr_here;
         assign wr_here = bus_wr && is_mask_word && (bus_sel == SEL_W'(b));

         intr_gather_bank #(
            .SYNC_STAGES (SYNC_STAGES)
         ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .src     (irq_src[b*SRC_PER_BANK +: SRC_PER_BANK]),
            .wr_en   (wr_here),
            .wr_slot (wr_slot),
            .wdata   (bus_wdata),
            .cause   (cause_a[b]),
            .mask_q  (mask_a[b]),
            .req     (req_a[b]),
            .top_vld (vld_a[b]),
            .top_idx (idx_a[b])
         );
      end
   endgenerate

   // merge requests across banks
   always_comb begin
      irq_norm = 1'b0;
      irq_fast = 1'b0;
      irq_endp = 1'b0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         irq_norm = irq_norm | req_a[b][MSK_NORM];
         irq_fast = irq_fast | req_a[b][MSK_FAST];
         irq_endp = irq_endp | req_a[b][MSK_ENDP];
      end
   end

   // read mux
   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (aligned && (bus_sel == SEL_W'(b))) begin
            case (word)
               WRD_CAUSE: bus_rdata = cause_a[b];
               WRD_NORM:  bus_rdata = mask_a[b][MSK_NORM];
               WRD_FAST:  bus_rdata = mask_a[b][MSK_FAST];
               WRD_ENDP:  bus_rdata = mask_a[b][MSK_ENDP];
               WRD_STAT: begin
                  bus_rdata[STAT_VLD_BIT]  = vld_a[b];
                  bus_rdata[IDX_W-1:0]     = idx_a[b];
               end
               default:   bus_rdata = '0;
            endcase
         end
      end
   end
endmodule

// File: rtl/intr_gather_chk.sv
module intr_gather_chk
   import intr_gather_pkg::*;
#(
   parameter int NUM_BANKS   = 3,
   parameter int SYNC_STAGES = 2,
   parameter int SEL_W       = 2
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic [NUM_BANKS*SRC_PER_BANK-1:0] irq_src,
   input logic                              bus_wr,
   input logic [SEL_W-1:0]                  bus_sel,
   input logic [OFF_W-1:0]                  bus_off,
   input logic [31:0]                       bus_wdata,
   input logic [31:0]                       bus_rdata,
   input logic                              irq_norm,
   input logic                              irq_fast,
   input logic                              irq_endp
);
   logic [1:0] warm;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             warm <= 2'd0;
      else if (warm != 2'd3)  warm <= warm + 2'd1;
   end

   // R1
   cause_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (SYNC_STAGES == 2 && warm == 2'd3 && bus_sel == '0 && bus_off == 5'h00)
         |-> bus_rdata == $past(irq_src[SRC_PER_BANK-1:0], 2));

   // R2
   mask_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_sel == '0 && bus_off == 5'h04)
         |=> ((bus_sel == '0 && bus_off == 5'h04) -> bus_rdata == $past(bus_wdata)));

   // R6
   stat_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_off == 5'h10)
         |-> (bus_rdata[31:9] == '0 && bus_rdata[7:5] == '0 &&
              (bus_rdata[STAT_VLD_BIT] || bus_rdata[4:0] == '0)));

   // R4
   norm_idle_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_norm && bus_off == 5'h10) |-> !bus_rdata[STAT_VLD_BIT]);

   // R8
   bad_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(bus_sel) >= NUM_BANKS || bus_off[1:0] != 2'b00 || bus_off > 5'h10)
         |-> bus_rdata == '0);
endmodule

bind intr_gather intr_gather_chk #(
   .NUM_BANKS   (NUM_BANKS),
   .SYNC_STAGES (SYNC_STAGES),
   .SEL_W       (SEL_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_src   (irq_src),
   .bus_wr    (bus_wr),
   .bus_sel   (bus_sel),
   .bus_off   (bus_off),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .irq_norm  (irq_norm),
   .irq_fast  (irq_fast),
   .irq_endp  (irq_endp)
);

// File: tb/intr_gather_bench.sv
`timescale 1ns/1ps
module intr_gather_bench;
   localparam int NB = 3;
   localparam int SW = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NB*32-1:0] irq_src = '0;
   logic            bus_wr = 1'b0;
   logic [SW-1:0]   bus_sel = '0;
   logic [4:0]      bus_off = '0;
   logic [31:0]     bus_wdata = '0;
   logic [31:0]     bus_rdata;
   logic            irq_norm, irq_fast, irq_endp;

   always #2 clk = ~clk;

   intr_gather u_intr_gather (
      .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_wr(bus_wr),
      .bus_sel(bus_sel), .bus_off(bus_off), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_norm(irq_norm), .irq_fast(irq_fast),
      .irq_endp(irq_endp)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // reference model: line history queue per bank, masks per bank
   logic [31:0] hist [NB][$];
   logic [31:0] msk  [NB][3];

   function automatic logic [31:0] m_cause(input int b);
      return (hist[b].size() >= 2) ? hist[b][hist[b].size()-2] : 32'h0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < NB; b++) begin
            hist[b].delete();
            for (int m = 0; m < 3; m++) msk[b][m] = 32'h0;
         end
      end else begin
         for (int b = 0; b < NB; b++) begin
            hist[b].push_back(irq_src[b*32 +: 32]);
            if (hist[b].size() > 2) void'(hist[b].pop_front());
         end
         if (bus_wr && int'(bus_sel) < NB && bus_off[1:0] == 2'b00 &&
             bus_off[4:2] >= 3'd1 && bus_off[4:2] <= 3'd3)
            msk[int'(bus_sel)][int'(bus_off[4:2]) - 1] = bus_wdata;
      end
   end

   function automatic logic [31:0] m_read();
      int b;
      logic [31:0] p;
      b = int'(bus_sel);
      if (b >= NB || bus_off[1:0] != 2'b00) return 32'h0;
      case (bus_off)
         5'h00: return m_cause(b);
         5'h04: return msk[b][0];
         5'h08: return msk[b][1];
         5'h0C: return msk[b][2];
         5'h10: begin
            p = m_cause(b) & msk[b][0];
            for (int i = 31; i >= 0; i--)
               if (p[i]) return 32'h100 | 32'(i);
            return 32'h0;
         end
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic m_out(input int m);
      logic r = 1'b0;
      for (int b = 0; b < NB; b++) r |= |(m_cause(b) & msk[b][m]);
      return r;
   endfunction

   function automatic string rd_tag();
      if (int'(bus_sel) >= NB || bus_off[1:0] != 0 || bus_off > 5'h10) return "R8 read";
      case (bus_off)
         5'h00:   return "R1 R3 cause";
         5'h10:   return "R6 status";
         default: return "R2 R3 mask";
      endcase
   endfunction

   // per-cycle comparison, away from the rising edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(rd_tag(), bus_rdata, m_read());
         chk("R4 irq_norm", 32'(irq_norm), 32'(m_out(0)));
         chk("R5 irq_fast", 32'(irq_fast), 32'(m_out(1)));
         chk("R5 irq_endp", 32'(irq_endp), 32'(m_out(2)));
      end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic wr(input int sel, input logic [4:0] off, input logic [31:0] d);
      bus_wr = 1'b1; bus_sel = SW'(sel); bus_off = off; bus_wdata = d;
      step();
      bus_wr = 1'b0;
   endtask

   task automatic rd_at(input int sel, input logic [4:0] off);
      bus_sel = SW'(sel); bus_off = off;
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      // R2 reset state of every mask and the status word
      for (int b = 0; b < NB; b++) begin
         rd_at(b, 5'h04); chk("R2 reset norm", bus_rdata, 32'h0);
         rd_at(b, 5'h08); chk("R2 reset fast", bus_rdata, 32'h0);
         rd_at(b, 5'h0C); chk("R2 reset endp", bus_rdata, 32'h0);
         rd_at(b, 5'h10); chk("R6 reset status", bus_rdata, 32'h0);
         step();
      end
      chk("R4 reset irq_norm", 32'(irq_norm), 32'h0);

      // walking single bit, all masks open on all banks
      for (int b = 0; b < NB; b++)
         for (int m = 1; m <= 3; m++) wr(b, 5'(m * 4), 32'hFFFF_FFFF);
      for (int k = 0; k < NB * 32; k++) begin
         irq_src = '0; irq_src[k] = 1'b1;
         bus_sel = SW'(k / 32); bus_off = (k % 2 == 0) ? 5'h00 : 5'h10;
         step(); step();
      end
      irq_src = '0; step(); step(); step();
      rd_at(0, 5'h00); chk("R1 cause clears when lines drop", bus_rdata, 32'h0);

      // R6 highest index among several pending
      irq_src[31:0] = 32'h0000_1224;
      step(); step();
      rd_at(0, 5'h10); chk("R6 highest index", bus_rdata, 32'h0000_010C);
      wr(0, 5'h04, 32'h0000_0024);
      rd_at(0, 5'h10); chk("R6 masked highest", bus_rdata, 32'h0000_0105);

      // R3 writes to cause and status ignored
      wr(0, 5'h00, 32'hFFFF_FFFF);
      wr(0, 5'h10, 32'hFFFF_FFFF);
      rd_at(0, 5'h00); chk("R3 cause after write", bus_rdata, 32'h0000_1224);
      rd_at(0, 5'h04); chk("R3 norm mask after write", bus_rdata, 32'h0000_0024);

      // R8 bad addresses: bank 3, misaligned, past status
      wr(3, 5'h04, 32'h1234_5678);
      wr(0, 5'h05, 32'h0);
      wr(0, 5'h14, 32'h0);
      rd_at(3, 5'h04); chk("R8 bank out of range", bus_rdata, 32'h0);
      rd_at(0, 5'h05); chk("R8 misaligned", bus_rdata, 32'h0);
      rd_at(0, 5'h04); chk("R8 write ignored", bus_rdata, 32'h0000_0024);

      // random phase
      for (int c = 0; c < 1500; c++) begin
         irq_src = {$urandom, $urandom, $urandom};
         if (c % 5 == 0) irq_src = '0;
         if ($urandom % 4 == 0) begin
            bus_wr = 1'b1;
            bus_wdata = $urandom & $urandom;
         end else bus_wr = 1'b0;
         bus_sel = SW'($urandom);
         bus_off = 5'($urandom);
         if ($urandom % 2 == 0) bus_off[1:0] = 2'b00;
         step();
      end
      bus_wr = 1'b0;

      // R7 zero normal masks, all lines high
      for (int b = 0; b < NB; b++) wr(b, 5'h04, 32'h0);
      wr(1, 5'h08, 32'h0000_0001);
      irq_src = '1;
      step(); step();
      rd_at(1, 5'h10);
      chk("R7 irq_norm silenced", 32'(irq_norm), 32'h0);
      chk("R7 status invalid", bus_rdata, 32'h0);
      chk("R5 fast still live", 32'(irq_fast), 32'h1);

      step();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule